// File: doc/BRIEF.md
# Byte-Accessed 16-bit Down Timer

This block is a 16-bit down-counting timer that sits behind an 8-bit data bus. Software reaches the timer one byte at a time. Byte strobes with a high/low select give access to two values. A read sees the live counter. A write goes to a 16-bit reload latch, and the counter copies that latch each time it underflows. Buffer registers make each two-byte access behave as a single 16-bit access. The counter value stays consistent across the two reads, and the latch changes in one step.

The access order is fixed. A read begins with the high byte. That read also captures the low half of the counter into a read buffer, and the following low-byte read returns the buffer. A write begins with the low byte, which waits in a write buffer. The high-byte write then moves both halves into the latch together.

A three-state sequencer keeps track of which sequence is open:

- States: `SEQ_IDLE`, `SEQ_RD_PEND` and `SEQ_WR_PEND`.
- Opening transitions:
  - From `SEQ_IDLE`, a high read goes to `SEQ_RD_PEND`.
  - From `SEQ_IDLE`, a low write goes to `SEQ_WR_PEND`.
- Closing transitions:
  - A low read closes a read sequence and returns to `SEQ_IDLE`.
  - A high write closes a write sequence and returns to `SEQ_IDLE`.
- Repeating the opening access keeps the same state.
- Crossing transitions: a write while `SEQ_RD_PEND`, or a read while `SEQ_WR_PEND`, does two things. It sets a sticky error flag. It is then carried out as if the sequencer had been idle.
- Collision: read and write strobes in the same cycle set the flag, do nothing else, and force `SEQ_IDLE`.

The counter decrements on each enabled cycle and holds while the stop input is high. When enabled at zero, it reloads from the latch and pulses an interrupt request.

Top module: `byte_timer16`

## Requirements
- R1: After reset, the counter and the reload latch are 16'hFFFF. Both byte buffers and `bus_rdata` are 8'h00. `irq` and `seq_err` are 0, and the sequencer is in `SEQ_IDLE`.
- R2: A read with `bus_hi`=1 puts the counter's upper byte on `bus_rdata` one cycle later. In the same cycle it captures the counter's lower byte. A later read with `bus_hi`=0 returns that captured byte, even if the counter has moved since.
- R3: A write with `bus_hi`=0 changes only the write buffer and leaves the latch unchanged. A write with `bus_hi`=1 loads the latch with {written byte, write buffer}.
- R4: In a cycle with `cnt_en`=1, `cnt_stop`=0 and a nonzero counter, the counter decreases by exactly one.
- R5: While `cnt_stop`=1, the counter holds its value whatever `cnt_en` does.
- R6: In a cycle with `cnt_en`=1, `cnt_stop`=0 and the counter at zero, the counter takes the latch value (as it was before that edge), and `irq` is 1 for the following cycle only.
- R7: A write strobe while in `SEQ_RD_PEND` sets `seq_err`, and the write still takes effect.
- R8: A read strobe while in `SEQ_WR_PEND` sets `seq_err`, and the read still takes effect.
- R9: When `bus_rd` and `bus_wr` are both 1 in the same cycle, `seq_err` is set. The latch, both buffers and `bus_rdata` are unchanged, and the sequencer returns to `SEQ_IDLE`.
- R10: `seq_err` stays set until a cycle with `err_clr`=1 and no new violation. When a violation and `err_clr` occur in the same cycle, the flag stays set.
- R11: `bus_rdata` changes only on a read strobe and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Byte read strobe, one cycle per byte |
| bus_wr | input | 1 | Byte write strobe, one cycle per byte |
| bus_hi | input | 1 | Byte select: 1 = high-order byte, 0 = low-order byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, registered |
| cnt_en | input | 1 | Count pulse; one decrement per enabled cycle |
| cnt_stop | input | 1 | Count stop; holds the counter while 1 |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| irq | output | 1 | One-cycle interrupt request on underflow |
| seq_err | output | 1 | Sticky access-order violation flag |

## Verification
The in-RTL properties check the following on every cycle:

- the single-step decrement;
- the hold under stop;
- the reload on underflow;
- latch stability without a high-byte write;
- error setting on both kinds of crossed sequence and on a strobe collision;
- the stickiness of the flag.

Some behaviours only the bench's scenarios can show, because they need a whole multi-cycle byte sequence followed by an observation through the bus:

- that a low read returns the byte captured by the earlier high read after the counter has moved on;
- that a lone low-byte write leaves the reload value in place until the high byte arrives;
- that the value reloaded after a full 16-bit countdown is the latched one.

// File: rtl/byte_timer16_pkg.sv
package byte_timer16_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_RD_PEND = 2'd1,
        SEQ_WR_PEND = 2'd2
    } seq_state_t;

endpackage

// File: rtl/bt_access_seq.sv
module bt_access_seq
    import byte_timer16_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic              hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              err_clr,
    output logic [BYTE_W-1:0] rdata,
    output logic [CNT_W-1:0]  latch_o,
    output logic              err_o
);

    seq_state_t        state_q, state_d;
    logic              viol;
    logic              do_rd, do_wr;
    logic [BYTE_W-1:0] wbuf_q, rbuf_q;

    assign do_rd = rd && !wr;
    assign do_wr = wr && !rd;

    // next state and violation detection
    always_comb begin
        state_d = state_q;
        viol    = 1'b0;
        if (rd && wr) begin
            state_d = SEQ_IDLE;
            viol    = 1'b1;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (wr)      state_d = hi ? SEQ_IDLE : SEQ_WR_PEND;
                    else if (rd) state_d = hi ? SEQ_RD_PEND : SEQ_IDLE;
                end
                SEQ_RD_PEND: begin
                    if (wr) begin
                        viol    = 1'b1;
                        state_d = hi ? SEQ_IDLE : SEQ_WR_PEND;
                    end else if (rd) begin
                        state_d = hi ? SEQ_RD_PEND : SEQ_IDLE;
                    end
                end
                SEQ_WR_PEND: begin
                    if (rd) begin
                        viol    = 1'b1;
                        state_d = hi ? SEQ_RD_PEND : SEQ_IDLE;
                    end else if (wr) begin
                        state_d = hi ? SEQ_IDLE : SEQ_WR_PEND;
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // buffers, latch, read data and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbuf_q  <= '0;
            rbuf_q  <= '0;
            rdata   <= '0;
            latch_o <= '1;
            err_o   <= 1'b0;
        end else begin
            if (do_wr) begin
                if (hi) latch_o <= {wdata, wbuf_q};
                else    wbuf_q  <= wdata;
            end
            if (do_rd) begin
                if (hi) begin
                    rdata  <= cnt_i[CNT_W-1:BYTE_W];
                    rbuf_q <= cnt_i[BYTE_W-1:0];
                end else begin
                    rdata  <= rbuf_q;
                end
            end
            if (viol)         err_o <= 1'b1;
            else if (err_clr) err_o <= 1'b0;
        end
    end

    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && hi) |=> latch_o == $past(latch_o));

    p_wr_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && state_q == SEQ_RD_PEND) |=> err_o);

    p_rd_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && state_q == SEQ_WR_PEND) |=> err_o);

    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wr) |=> (err_o && state_q == SEQ_IDLE && rdata == $past(rdata)));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr) |=> err_o);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata == $past(rdata));

endmodule

// File: rtl/bt_down_counter.sv
module bt_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stop,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);

    logic step, at_zero;

    assign step    = en && !stop;
    assign at_zero = (cnt_o == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '1;
            irq_o <= 1'b0;
        end else begin
            irq_o <= step && at_zero;
            if (step) cnt_o <= at_zero ? reload_i : cnt_o - 1'b1;
        end
    end

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !stop && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);

    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> cnt_o == $past(cnt_o));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !stop && cnt_o == '0) |=> (cnt_o == $past(reload_i) && irq_o));

endmodule

// File: rtl/byte_timer16.sv
module byte_timer16 #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_hi,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_en,
    input  logic              cnt_stop,
    input  logic              err_clr,
    output logic              irq,
    output logic              seq_err
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;

    bt_access_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .hi      (bus_hi),
        .wdata   (bus_wdata),
        .cnt_i   (count),
        .err_clr (err_clr),
        .rdata   (bus_rdata),
        .latch_o (reload),
        .err_o   (seq_err)
    );

    bt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cnt_en),
        .stop     (cnt_stop),
        .reload_i (reload),
        .cnt_o    (count),
        .irq_o    (irq)
    );

endmodule

// File: tb/byte_timer16_bench.sv
module byte_timer16_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0, bus_hi = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cnt_en = 1'b0, cnt_stop = 1'b0, err_clr = 1'b0;
    logic       irq, seq_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit live  = 1'b0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_timer16 u_byte_timer16 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_hi(bus_hi), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_en(cnt_en), .cnt_stop(cnt_stop), .err_clr(err_clr),
        .irq(irq), .seq_err(seq_err)
    );

    // behavioural reference: 0 idle, 1 read open, 2 write open
    logic [15:0] m_cnt = 16'hFFFF, m_lat = 16'hFFFF, m_cnt_old;
    logic [7:0]  m_wb = 8'h00, m_rb = 8'h00, m_rd = 8'h00;
    int          m_pend = 0;
    bit          m_err = 1'b0, m_irq = 1'b0, m_viol;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 16'hFFFF; m_lat = 16'hFFFF; m_wb = 0; m_rb = 0; m_rd = 0;
            m_pend = 0; m_err = 0; m_irq = 0;
        end else begin
            m_cnt_old = m_cnt;
            m_viol = (bus_rd && bus_wr) || (bus_wr && m_pend == 1) || (bus_rd && m_pend == 2);
            m_irq = cnt_en && !cnt_stop && (m_cnt == 16'h0000);
            if (cnt_en && !cnt_stop) m_cnt = (m_cnt == 16'h0000) ? m_lat : m_cnt - 16'd1;
            if (bus_rd && bus_wr) begin
                m_pend = 0;
            end else if (bus_wr) begin
                if (bus_hi) begin m_lat = {bus_wdata, m_wb}; m_pend = 0; end
                else        begin m_wb = bus_wdata; m_pend = 2; end
            end else if (bus_rd) begin
                if (bus_hi) begin m_rd = m_cnt_old[15:8]; m_rb = m_cnt_old[7:0]; m_pend = 1; end
                else        begin m_rd = m_rb; m_pend = 0; end
            end
            if (m_viol) m_err = 1'b1;
            else if (err_clr) m_err = 1'b0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, sampled mid-period
    always @(negedge clk) begin
        if (live && !done) begin
            check("R2/R11 rdata vs model", bus_rdata, m_rd);
            check("R6 irq vs model", irq, m_irq);
            check("R7/R8/R10 seq_err vs model", seq_err, m_err);
        end
    end

    task automatic access(input bit rd, input bit wr, input bit hi, input logic [7:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_hi = hi; bus_wdata = d;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; bus_hi = 0; bus_wdata = 8'h00;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_en = 1'b1;
            @(negedge clk); cnt_en = 1'b0;
        end
    endtask

    task automatic read16(input string tag, input logic [15:0] exp);
        logic [7:0] h;
        access(1, 0, 1, 8'h00); h = bus_rdata;
        access(1, 0, 0, 8'h00);
        check(tag, {h, bus_rdata}, exp);
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 irq after reset", irq, 0);
        check("R1 seq_err after reset", seq_err, 0);
        read16("R1 counter after reset", 16'hFFFF);

        // R4 single decrements
        pulses(3);
        read16("R4 three decrements", 16'hFFFC);

        // R2 captured low byte survives counter movement
        access(1, 0, 1, 8'h00);
        check("R2 high byte", bus_rdata, 8'hFF);
        pulses(5);
        access(1, 0, 0, 8'h00);
        check("R2 captured low byte", bus_rdata, 8'hFC);

        // R11 rdata holds across idle cycles
        repeat (4) @(negedge clk);
        check("R11 rdata held", bus_rdata, 8'hFC);

        // R5 stop holds the counter
        @(negedge clk); cnt_stop = 1'b1; cnt_en = 1'b1;
        repeat (4) @(negedge clk);
        cnt_stop = 1'b0; cnt_en = 1'b0;
        read16("R5 held under stop", 16'hFFF7);

        // R3 load latch with 0x0005, R6 full countdown and reload
        access(0, 1, 0, 8'h05);
        access(0, 1, 1, 8'h00);
        @(negedge clk); cnt_en = 1'b1;
        while (irq !== 1'b1) @(negedge clk);
        cnt_en = 1'b0;
        check("R6 irq asserted on underflow", irq, 1);
        @(negedge clk);
        check("R6 irq one cycle only", irq, 0);
        read16("R6 reload value", 16'h0005);

        // R3 lone low write leaves latch alone
        access(0, 1, 0, 8'h02);
        pulses(6);
        access(0, 1, 1, 8'h00);
        read16("R3 reload used old latch", 16'h0005);
        pulses(6);
        read16("R3 reload after high write", 16'h0002);

        // R7 write while read open
        access(1, 0, 1, 8'h00);
        access(0, 1, 0, 8'h09);
        check("R7 error after crossed write", seq_err, 1);
        clear_err();
        check("R10 cleared by err_clr", seq_err, 0);
        // R8 read while write open
        access(1, 0, 1, 8'h00);
        check("R8 error after crossed read", seq_err, 1);
        check("R8 read still performed", bus_rdata, 8'h00);
        repeat (3) @(negedge clk);
        check("R10 flag sticky", seq_err, 1);
        access(1, 0, 0, 8'h00);
        clear_err();

        // R9 collision leaves latch and rdata untouched
        access(1, 1, 1, 8'h77);
        check("R9 error on collision", seq_err, 1);
        check("R9 rdata unchanged", bus_rdata, 8'h02);
        clear_err();
        pulses(3);
        read16("R9 latch unchanged by collision", 16'h0002);

        // R10 set wins over clear
        @(negedge clk); bus_rd = 1; bus_wr = 1; err_clr = 1;
        @(negedge clk); bus_rd = 0; bus_wr = 0; err_clr = 0;
        check("R10 violation beats clear", seq_err, 1);
        clear_err();
        check("R10 final clear", seq_err, 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule